// File: doc/BRIEF.md
# CPU Reset Exception Sequencer

This block runs the start-up sequence of a small 32-bit processor. The sequence begins when the reset input is released. The sequencer first writes two hardware-description words into data registers 0 and 1, so that a debug probe can read which options were built into the core. It then loads the status register with its start value and clears the vector base register. Next it fetches two longwords over a simple read bus: the supervisor stack pointer from address 0, then the start program counter from address 4. Finally it opens instruction fetch at the loaded program counter.

Reset has the highest priority. It acts asynchronously and abandons any read in progress; that read is never resumed. The sequence always restarts from its first step. A bus error on either vector read halts the sequencer, and so does an odd start program counter, which counts as an address error. The halt holds until the next reset, and no instruction is ever fetched from it. The enable for the memory controllers stays low until fetch opens.

Top module: `boot_exc_seq`

## Requirements
- R1: While `rst_n` is low, the block drives all of these low or zero: `bus_req`, `fetch_en`, `halted`, `mem_en`, and every register output. Asserting reset abandons any pending read, and after release the sequence starts again with the configuration step.
- R2: On the first rising clock edge after reset is released, `cfg_d0` takes the value {FAMILY_ID[7:0] in bits 31:24, CORE_REV[3:0] in bits 23:20, divider-present in bit 4, multiply-accumulate-present in bit 3, all other bits zero}. On the same edge `cfg_d1` takes {ROM_CODE in bits 31:16, RAM_CODE in bits 15:0}. At that point `sr_out` is still zero.
- R3: On the second edge after release, `sr_out` becomes 16'h2700 and `vbr_out` becomes 0. In that value trace (bit 15) is 0, supervisor (bit 13) is 1, master (bit 12) is 0, and the interrupt mask (bits 10:8) is 3'b111.
- R4: The first read targets address 0. The block holds `bus_req` high and `bus_addr` stable until `bus_ack` or `bus_err`. Data returned with `bus_ack` loads `ssp_out`.
- R5: The second read targets address 4, and data returned with `bus_ack` loads `pc_out`. There are exactly two reads, in the order 0 then 4.
- R6: After a successful second read with an even value, `fetch_en` rises with `pc_out` holding the fetched value. No further bus request follows.
- R7: `bus_err` during either read takes precedence over `bus_ack`. It sets `halted`, leaves the target register unchanged, and stops all further requests. `halted` stays high and `fetch_en` stays low until reset.
- R8: An odd value returned by the second read is an address error. It sets `halted` and leaves `pc_out` at zero.
- R9: `mem_en` stays low throughout the sequence and in the halt state. It goes high only together with `fetch_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | output | 1 | Read request, held until acknowledge or error |
| bus_addr | output | ADDR_W | Read address |
| bus_ack | input | 1 | Read acknowledge with valid data |
| bus_err | input | 1 | Read terminated with an error |
| bus_rdata | input | 32 | Read data |
| cfg_d0 | output | 32 | Data register 0 (core configuration word) |
| cfg_d1 | output | 32 | Data register 1 (memory configuration word) |
| sr_out | output | 16 | Status register |
| vbr_out | output | 32 | Vector base register |
| ssp_out | output | 32 | Supervisor stack pointer |
| pc_out | output | 32 | Program counter |
| fetch_en | output | 1 | Instruction fetch released |
| halted | output | 1 | Fault-on-fault halt |
| mem_en | output | 1 | Memory controller enable |

## Verification
The assertions assume that the bus answers only a raised request, with single-cycle pulses on `bus_ack` or `bus_err`. They also assume that a response belongs to the address shown in the same cycle. The bench's bus model follows both rules. It counts a programmable wait from the moment a request appears, answers once, and then clears its count, so every answer lands on the request it serves. An error is sent with acknowledge also raised, which exercises the precedence rule without breaking the single-pulse rule.

// File: rtl/boot_seq_pkg.sv
`timescale 1ns/1ps
package boot_seq_pkg;

  localparam int WORD_W = 32;
  localparam int SR_W   = 16;

  typedef enum logic [2:0] {
    ST_CFG    = 3'd0,
    ST_SRINIT = 3'd1,
    ST_RD_SSP = 3'd2,
    ST_RD_PC  = 3'd3,
    ST_RUN    = 3'd4,
    ST_HALT   = 3'd5
  } seq_st_t;

  // status register field positions
  localparam int SR_T_BIT = 15;
  localparam int SR_S_BIT = 13;
  localparam int SR_M_BIT = 12;
  localparam int SR_I_LO  = 8;

  // status value applied by the reset exception
  function automatic logic [SR_W-1:0] sr_reset_word();
    logic [SR_W-1:0] w;
    w = '0;
    w[SR_T_BIT] = 1'b0;
    w[SR_S_BIT] = 1'b1;
    w[SR_M_BIT] = 1'b0;
    w[SR_I_LO +: 3] = 3'b111;
    return w;
  endfunction

  // core configuration word
  function automatic logic [WORD_W-1:0] cfg_core_word(
    input logic [7:0] fam,
    input logic [3:0] rev,
    input logic       has_div,
    input logic       has_mac
  );
    logic [WORD_W-1:0] w;
    w = '0;
    w[31:24] = fam;
    w[23:20] = rev;
    w[4]     = has_div;
    w[3]     = has_mac;
    return w;
  endfunction

  // memory configuration word
  function automatic logic [WORD_W-1:0] cfg_mem_word(
    input logic [15:0] rom_code,
    input logic [15:0] ram_code
  );
    return {rom_code, ram_code};
  endfunction

endpackage

// File: rtl/boot_seq_ctl.sv
`timescale 1ns/1ps
module boot_seq_ctl
  import boot_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rd_ok,
  input  logic    rd_bad,
  input  logic    rd_odd,
  output seq_st_t state
);

  seq_st_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_CFG:    nxt = ST_SRINIT;
      ST_SRINIT: nxt = ST_RD_SSP;
      ST_RD_SSP: begin
        if (rd_bad)      nxt = ST_HALT;
        else if (rd_ok)  nxt = ST_RD_PC;
      end
      ST_RD_PC: begin
        if (rd_bad || (rd_ok && rd_odd)) nxt = ST_HALT;
        else if (rd_ok)                  nxt = ST_RUN;
      end
      ST_RUN:    nxt = ST_RUN;
      ST_HALT:   nxt = ST_HALT;
      default:   nxt = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_CFG;
    else        state <= nxt;
  end

endmodule

// File: rtl/boot_rd_port.sv
`timescale 1ns/1ps
module boot_rd_port
  import boot_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              rst_n,
  input  seq_st_t           state,
  input  logic              bus_ack,
  input  logic              bus_err,
  input  logic [WORD_W-1:0] bus_rdata,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              rd_ok,
  output logic              rd_bad,
  output logic              rd_odd
);

  localparam logic [ADDR_W-1:0] SSP_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] PC_ADDR  = ADDR_W'(4);

  always_comb begin
    bus_req  = rst_n && ((state == ST_RD_SSP) || (state == ST_RD_PC));
    bus_addr = (state == ST_RD_PC) ? PC_ADDR : SSP_ADDR;
  end

  // error wins over acknowledge
  assign rd_bad = bus_req && bus_err;
  assign rd_ok  = bus_req && bus_ack && !bus_err;
  assign rd_odd = bus_rdata[0];

endmodule

// File: rtl/boot_arch_regs.sv
`timescale 1ns/1ps
module boot_arch_regs
  import boot_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_cfg,
  input  logic              ev_sr,
  input  logic              ev_ssp,
  input  logic              ev_pc,
  input  logic [WORD_W-1:0] core_word,
  input  logic [WORD_W-1:0] mem_word,
  input  logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] d0_q,
  output logic [WORD_W-1:0] d1_q,
  output logic [SR_W-1:0]   sr_q,
  output logic [WORD_W-1:0] vbr_q,
  output logic [WORD_W-1:0] ssp_q,
  output logic [WORD_W-1:0] pc_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d0_q  <= '0;
      d1_q  <= '0;
      sr_q  <= '0;
      vbr_q <= '0;
      ssp_q <= '0;
      pc_q  <= '0;
    end else begin
      if (ev_cfg) begin
        d0_q <= core_word;
        d1_q <= mem_word;
      end
      if (ev_sr) begin
        sr_q  <= sr_reset_word();
        vbr_q <= '0;
      end
      if (ev_ssp) ssp_q <= rdata;
      if (ev_pc)  pc_q  <= rdata;
    end
  end

endmodule

// File: rtl/boot_exc_seq.sv
`timescale 1ns/1ps
module boot_exc_seq
  import boot_seq_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter logic [7:0]  FAMILY_ID = 8'h4A,
  parameter logic [3:0]  CORE_REV  = 4'h3,
  parameter bit          HAS_DIV   = 1'b1,
  parameter bit          HAS_MAC   = 1'b1,
  parameter logic [15:0] ROM_CODE  = 16'h0040,
  parameter logic [15:0] RAM_CODE  = 16'h0008
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_ack,
  input  logic              bus_err,
  input  logic [31:0]       bus_rdata,
  output logic [31:0]       cfg_d0,
  output logic [31:0]       cfg_d1,
  output logic [15:0]       sr_out,
  output logic [31:0]       vbr_out,
  output logic [31:0]       ssp_out,
  output logic [31:0]       pc_out,
  output logic              fetch_en,
  output logic              halted,
  output logic              mem_en
);

  seq_st_t state;
  logic rd_ok, rd_bad, rd_odd;

  // named internal events
  logic ev_cfg, ev_sr, ev_ssp, ev_pc, ev_fault;

  localparam logic [WORD_W-1:0] CORE_WORD =
    cfg_core_word(FAMILY_ID, CORE_REV, HAS_DIV, HAS_MAC);
  localparam logic [WORD_W-1:0] MEM_WORD = cfg_mem_word(ROM_CODE, RAM_CODE);

  boot_seq_ctl u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_ok  (rd_ok),
    .rd_bad (rd_bad),
    .rd_odd (rd_odd),
    .state  (state)
  );

  boot_rd_port #(.ADDR_W(ADDR_W)) u_port (
    .rst_n     (rst_n),
    .state     (state),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err),
    .bus_rdata (bus_rdata),
    .bus_req   (bus_req),
    .bus_addr  (bus_addr),
    .rd_ok     (rd_ok),
    .rd_bad    (rd_bad),
    .rd_odd    (rd_odd)
  );

  assign ev_cfg   = (state == ST_CFG);
  assign ev_sr    = (state == ST_SRINIT);
  assign ev_ssp   = (state == ST_RD_SSP) && rd_ok;
  assign ev_pc    = (state == ST_RD_PC) && rd_ok && !rd_odd;
  assign ev_fault = rd_bad || ((state == ST_RD_PC) && rd_ok && rd_odd);

  boot_arch_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_cfg    (ev_cfg),
    .ev_sr     (ev_sr),
    .ev_ssp    (ev_ssp),
    .ev_pc     (ev_pc),
    .core_word (CORE_WORD),
    .mem_word  (MEM_WORD),
    .rdata     (bus_rdata),
    .d0_q      (cfg_d0),
    .d1_q      (cfg_d1),
    .sr_q      (sr_out),
    .vbr_q     (vbr_out),
    .ssp_q     (ssp_out),
    .pc_q      (pc_out)
  );

  assign fetch_en = rst_n && (state == ST_RUN);
  assign halted   = rst_n && (state == ST_HALT);
  assign mem_en   = fetch_en;

endmodule

// File: rtl/boot_exc_seq_chk.sv
`timescale 1ns/1ps
module boot_exc_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ack,
  input logic              bus_err,
  input logic [15:0]       sr_out,
  input logic [31:0]       vbr_out,
  input logic [31:0]       pc_out,
  input logic              fetch_en,
  input logic              halted,
  input logic              mem_en,
  input logic              ev_ssp,
  input logic              ev_pc,
  input logic              ev_fault
);

  always_comb begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (!bus_req && !fetch_en && !halted && !mem_en);
    end
  end

  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack && !bus_err) |=> (bus_req && $stable(bus_addr)));

  a_r4_ssp_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ssp |-> (bus_addr == ADDR_W'(0)));

  a_r5_pc_from_four: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pc |-> (bus_addr == ADDR_W'(4)));

  a_r3_sr_at_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en |-> (sr_out == 16'h2700 && vbr_out == 32'h0));

  a_r6_no_req_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en |=> (fetch_en && !bus_req));

  a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !bus_req && !fetch_en));

  a_r7_fault_halts: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |=> halted);

  a_r8_even_pc: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en |-> !pc_out[0]);

  a_r9_mem_off: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_en |-> !mem_en);

endmodule

bind boot_exc_seq boot_exc_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_req  (bus_req),
  .bus_addr (bus_addr),
  .bus_ack  (bus_ack),
  .bus_err  (bus_err),
  .sr_out   (sr_out),
  .vbr_out  (vbr_out),
  .pc_out   (pc_out),
  .fetch_en (fetch_en),
  .halted   (halted),
  .mem_en   (mem_en),
  .ev_ssp   (ev_ssp),
  .ev_pc    (ev_pc),
  .ev_fault (ev_fault)
);

// File: tb/tb_boot_exc_seq.sv
`timescale 1ns/1ps
module tb_boot_exc_seq;

  localparam logic [7:0]  FAM = 8'h4A;
  localparam logic [3:0]  REV = 4'h3;
  localparam bit          DIV = 1'b1;
  localparam bit          MAC = 1'b0;
  localparam logic [15:0] ROM = 16'h0040;
  localparam logic [15:0] RAM = 16'h0008;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        bus_req, bus_ack, bus_err;
  logic [31:0] bus_addr, bus_rdata;
  logic [31:0] cfg_d0, cfg_d1, vbr_out, ssp_out, pc_out;
  logic [15:0] sr_out;
  logic        fetch_en, halted, mem_en;

  boot_exc_seq #(
    .ADDR_W(32), .FAMILY_ID(FAM), .CORE_REV(REV), .HAS_DIV(DIV),
    .HAS_MAC(MAC), .ROM_CODE(ROM), .RAM_CODE(RAM)
  ) dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .cfg_d0(cfg_d0), .cfg_d1(cfg_d1), .sr_out(sr_out), .vbr_out(vbr_out),
    .ssp_out(ssp_out), .pc_out(pc_out), .fetch_en(fetch_en),
    .halted(halted), .mem_en(mem_en)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // bus model state; mode 0 ok, 1 error on read 0, 2 error on read 4, 3 odd pc
  int lat  = 0;
  int mode = 0;
  int wcnt = 0;
  int log_n = 0;
  logic [31:0] log_addr [8];

  function automatic logic [31:0] ssp_val(int l);
    return 32'h2000_1000 - 32'(l * 16);
  endfunction

  function automatic logic [31:0] pc_val(int l, int m);
    return 32'h0000_0410 + 32'(l * 8) + ((m == 3) ? 32'd1 : 32'd0);
  endfunction

  localparam logic [31:0] EXP_D0 =
    (32'(FAM) << 24) | (32'(REV) << 20) | (32'(DIV) << 4) | (32'(MAC) << 3);
  localparam logic [31:0] EXP_D1 = (32'(ROM) << 16) | 32'(RAM);

  initial begin
    bus_ack = 1'b0; bus_err = 1'b0; bus_rdata = '0;
  end

  always @(negedge clk) begin
    bus_ack = 1'b0;
    bus_err = 1'b0;
    bus_rdata = '0;
    if (!bus_req) wcnt = 0;
    else if (wcnt < lat) wcnt++;
    else begin
      wcnt = 0;
      if (log_n < 8) log_addr[log_n] = bus_addr;
      log_n++;
      bus_ack = 1'b1;
      if ((mode == 1 && bus_addr == 32'h0) || (mode == 2 && bus_addr == 32'h4))
        bus_err = 1'b1;
      else
        bus_rdata = (bus_addr == 32'h0) ? ssp_val(lat) : pc_val(lat, mode);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s lat=%0d mode=%0d actual=%h expected=%h", tag, lat, mode, act, exp);
    end
  endtask

  task automatic wait_end(output int mem_bad);
    mem_bad = 0;
    for (int i = 0; i < 30 && !fetch_en && !halted; i++) begin
      @(posedge clk); #5;
      if (!fetch_en && mem_en) mem_bad++;
    end
  endtask

  task automatic run_case(input int l, input int m);
    int mb;
    lat = l; mode = m;
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #5;
    // R1 reset state
    chk(!bus_req && !fetch_en && !halted && !mem_en, "R1 outputs quiet",
        {28'h0, bus_req, fetch_en, halted, mem_en}, 32'h0);
    chk(cfg_d0 == 0 && pc_out == 0 && ssp_out == 0 && sr_out == 0, "R1 regs clear",
        cfg_d0 | pc_out | ssp_out, 32'h0);
    @(negedge clk) begin rst_n = 1'b1; log_n = 0; end
    @(posedge clk); #5;
    chk(cfg_d0 == EXP_D0, "R2 d0 word", cfg_d0, EXP_D0);
    chk(cfg_d1 == EXP_D1, "R2 d1 word", cfg_d1, EXP_D1);
    chk(sr_out == 16'h0, "R2 cfg before sr", 32'(sr_out), 32'h0);
    @(posedge clk); #5;
    chk(sr_out == 16'h2700, "R3 sr value", 32'(sr_out), 32'h2700);
    chk(vbr_out == 32'h0, "R3 vbr zero", vbr_out, 32'h0);
    chk(bus_req && bus_addr == 32'h0, "R4 first read at 0", bus_addr, 32'h0);
    chk(!mem_en, "R9 mem off in sequence", 32'(mem_en), 32'h0);
    wait_end(mb);
    chk(mb == 0, "R9 mem off while waiting", 32'(mb), 32'h0);
    case (m)
      0: begin
        chk(fetch_en && !halted, "R6 fetch released", {31'h0, fetch_en}, 32'h1);
        chk(ssp_out == ssp_val(l), "R4 ssp loaded", ssp_out, ssp_val(l));
        chk(pc_out == pc_val(l, m), "R5 pc loaded", pc_out, pc_val(l, m));
        chk(log_n == 2 && log_addr[0] == 32'h0 && log_addr[1] == 32'h4,
            "R5 read order", log_addr[1], 32'h4);
        chk(mem_en, "R9 mem on with fetch", 32'(mem_en), 32'h1);
      end
      1: begin
        chk(halted && !fetch_en, "R7 halt on err read0", {31'h0, halted}, 32'h1);
        chk(ssp_out == 0 && log_n == 1, "R7 ssp untouched", ssp_out, 32'h0);
      end
      2: begin
        chk(halted && !fetch_en, "R7 halt on err read4", {31'h0, halted}, 32'h1);
        chk(ssp_out == ssp_val(l), "R7 ssp kept", ssp_out, ssp_val(l));
        chk(pc_out == 0 && log_n == 2, "R7 pc untouched", pc_out, 32'h0);
      end
      default: begin
        chk(halted && !fetch_en, "R8 halt on odd pc", {31'h0, halted}, 32'h1);
        chk(pc_out == 0, "R8 pc not loaded", pc_out, 32'h0);
        chk(!mem_en, "R9 mem off in halt", 32'(mem_en), 32'h0);
      end
    endcase
    begin
      int ln;
      ln = log_n;
      repeat (6) @(posedge clk);
      #5;
      chk(!bus_req && log_n == ln, "R6 R7 no further reads", 32'(log_n), 32'(ln));
      if (m == 0) chk(fetch_en && !halted, "R6 fetch stays", {31'h0, fetch_en}, 32'h1);
      else        chk(halted && !fetch_en, "R7 halt sticky", {31'h0, halted}, 32'h1);
    end
  endtask

  task automatic abort_case();
    int mb;
    lat = 3; mode = 0;
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) begin rst_n = 1'b1; log_n = 0; end
    repeat (3) @(posedge clk);
    #5;
    chk(bus_req && bus_addr == 32'h0, "R1 read pending before abort", bus_addr, 32'h0);
    @(negedge clk) rst_n = 1'b0;
    #5;
    chk(!bus_req && ssp_out == 0 && cfg_d0 == 0, "R1 abort clears", ssp_out, 32'h0);
    @(negedge clk) begin rst_n = 1'b1; log_n = 0; end
    repeat (2) @(posedge clk);
    wait_end(mb);
    chk(fetch_en && log_n == 2 && log_addr[0] == 32'h0, "R1 restart from start",
        log_addr[0], 32'h0);
    chk(ssp_out == ssp_val(3) && pc_out == pc_val(3, 0), "R5 values after restart",
        pc_out, pc_val(3, 0));
  endtask

  initial begin
    for (int m = 0; m < 4; m++)
      for (int l = 0; l < 4; l++)
        run_case(l, m);
    abort_case();
    run_case(1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule